// File: doc/BRIEF.md
# Multi-Gain Range Selector and Sample Formatter

This block sits between four parallel amplifier paths of one detector channel and a pipelined 12-bit converter. The four paths have gains of 1, 5, 9 and 33, and all four are sampled together on every sample clock. Each path has a saturation comparator. On every clock the block reads the four comparator flags, picks the path with the highest gain that is still below its saturation threshold, and registers a select for the analog multiplexer that feeds the converter. If every path is saturated, it falls back to the unity-gain path.

The converter returns its mantissa a fixed number of cycles after the select was set. The block delays the chosen range code by the same number of cycles and joins it with the mantissa of the same sample. The result is a floating-point word made of a type flag, a 2-bit range code and the 12-bit mantissa, with a valid flag.

A mode input switches the multiplexer to its four monitoring inputs (temperature, leakage current and internal checks). A 2-bit channel input picks one of them. Monitor words carry a type flag of 1 and the channel number in the code field.

Top module: `gain_fmt_top`

## Requirements
- R1: In data mode, `mux_sel[2]` is 0 and `mux_sel[1:0]` is the code of the highest-gain unsaturated path. `sat_flags[i]` belongs to code i, with codes 0 = ×33, 1 = ×9, 2 = ×5 and 3 = ×1. The lowest index that is not saturated wins.
- R2: When all four `sat_flags` bits are 1 in data mode, `mux_sel` is 3'b011 (×1).
- R3: `mux_sel` is registered: it reflects the inputs sampled at the previous rising edge.
- R4: In monitor mode (`mon_mode` = 1), `mux_sel` is {1, `mon_chan`}, and `sat_flags` has no effect on it.
- R5: `word_out` is packed as follows: bit 14 is the type flag (0 data, 1 monitor), bits 13:12 are the range code and bits 11:0 are the mantissa.
- R6: The word registered at edge e carries the select chosen at edge e−4 (converter latency 3, plus one capture stage) and the `adc_data` sampled at edge e.
- R7: `word_valid` stays 0 for the first 4 rising edges after reset is released, and is 1 from the 5th edge on.
- R8: `word_out` is zero whenever `word_valid` is 0.
- R9: A synchronous low `rst_n` sets `mux_sel` to 3'b011, `word_valid` to 0 and `word_out` to 0 at the next edge, and refills the pipeline from empty.
- R10: A monitor word has type flag 1 and the monitored channel number in the code field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sat_flags | input | 4 | Saturation flag per gain path, bit i for code i |
| mon_mode | input | 1 | 1 selects the monitoring inputs |
| mon_chan | input | 2 | Monitoring input number |
| adc_data | input | 12 | Converter mantissa |
| mux_sel | output | 3 | Analog multiplexer select {monitor, code} |
| word_out | output | 15 | Formatted word {flag, code, mantissa} |
| word_valid | output | 1 | word_out holds a full sample |

## Verification
The selector is tested with random comparator patterns, then with directed ones. The directed patterns are: no path saturated, exactly one unsaturated path at each position, gaps such as 4'b1010 that separate priority order from a plain count, and all paths saturated for the fallback. The converter model drives a mantissa that is a function of the sample index. Any error of one cycle in the code delay therefore pairs a code with the wrong mantissa. Monitor bursts with all four channels and changing saturation flags show that monitor mode ignores the comparators. A reset in the middle of the run checks that the pipeline refill and the valid rise happen again.

// File: rtl/gfmt_pkg.sv
// Package: shared defaults and code names for the gain range formatter.
// Assumes four gain paths ordered from highest to lowest gain.
package gfmt_pkg;
    localparam int DEF_N_PATH  = 4;
    localparam int DEF_MANT_W  = 12;
    localparam int DEF_ADC_LAT = 3;

    typedef enum logic [1:0] {
        RNG_X33 = 2'd0,
        RNG_X9  = 2'd1,
        RNG_X5  = 2'd2,
        RNG_X1  = 2'd3
    } rng_code_e;
endpackage

// File: rtl/gfmt_pick.sv
// Module: priority pick of the highest-gain unsaturated path.
// Assumes sat[0] is the highest gain. With all paths saturated it
// returns the index of the lowest gain path (N_PATH-1).
module gfmt_pick #(
    parameter int N_PATH = 4,
    parameter int CODE_W = $clog2(N_PATH)
) (
    input  logic [N_PATH-1:0] sat,
    output logic [CODE_W-1:0] code
);
    // Scan from lowest gain to highest so the highest unsaturated gain wins.
    always_comb begin
        code = CODE_W'(N_PATH - 1);
        for (int i = N_PATH - 1; i >= 0; i--) begin
            if (!sat[i]) code = CODE_W'(i);
        end
    end
endmodule

// File: rtl/gfmt_sel_reg.sv
// Module: registers the multiplexer select and the sample tag.
// Assumes mon_chan is only used in monitor mode. The reset select is
// the unity-gain path.
module gfmt_sel_reg #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_mode,
    input  logic [CODE_W-1:0] mon_chan,
    input  logic [CODE_W-1:0] pick_code,
    output logic              tag_live,
    output logic              tag_mon,
    output logic [CODE_W-1:0] tag_code
);
    // Capture the select for this sample clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_live <= 1'b0;
            tag_mon  <= 1'b0;
            tag_code <= '1;
        end else begin
            tag_live <= 1'b1;
            tag_mon  <= mon_mode;
            tag_code <= mon_mode ? mon_chan : pick_code;
        end
    end
endmodule

// File: rtl/gfmt_delay.sv
// Module: a fixed-depth register chain that matches the converter latency.
// Assumes DEPTH >= 1. All stages clear on reset.
module gfmt_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // Move the tag one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[s] <= '0;
            else if (s == 0) stage[s] <= din;
            else             stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/gfmt_pack.sv
// Module: joins the delayed tag and the mantissa into the output word.
// Assumes the tag arriving here belongs to the sample on adc_data.
// The word is forced to zero while it is not valid.
module gfmt_pack #(
    parameter int CODE_W = 2,
    parameter int MANT_W = 12,
    localparam int WORD_W = 1 + CODE_W + MANT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_live,
    input  logic              in_mon,
    input  logic [CODE_W-1:0] in_code,
    input  logic [MANT_W-1:0] adc_data,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    // Capture the packed word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= in_live;
            word_out   <= in_live ? {in_mon, in_code, adc_data} : '0;
        end
    end
endmodule

// File: rtl/gain_fmt_top.sv
// Module: gain range selector and floating-point formatter, top level.
// Assumes the converter returns the mantissa ADC_LAT cycles after the
// select register changes.
module gain_fmt_top #(
    parameter int N_PATH  = gfmt_pkg::DEF_N_PATH,
    parameter int MANT_W  = gfmt_pkg::DEF_MANT_W,
    parameter int ADC_LAT = gfmt_pkg::DEF_ADC_LAT,
    localparam int CODE_W = $clog2(N_PATH),
    localparam int WORD_W = 1 + CODE_W + MANT_W,
    localparam int TAG_W  = 2 + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PATH-1:0] sat_flags,
    input  logic              mon_mode,
    input  logic [CODE_W-1:0] mon_chan,
    input  logic [MANT_W-1:0] adc_data,
    output logic [CODE_W:0]   mux_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic [CODE_W-1:0] pick_code;
    logic              tag_live;
    logic              tag_mon;
    logic [CODE_W-1:0] tag_code;
    logic [TAG_W-1:0]  tag_late;

    gfmt_pick #(.N_PATH(N_PATH), .CODE_W(CODE_W)) pick_i (
        .sat  (sat_flags),
        .code (pick_code)
    );

    gfmt_sel_reg #(.CODE_W(CODE_W)) sel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_mode  (mon_mode),
        .mon_chan  (mon_chan),
        .pick_code (pick_code),
        .tag_live  (tag_live),
        .tag_mon   (tag_mon),
        .tag_code  (tag_code)
    );

    assign mux_sel = {tag_mon, tag_code};

    gfmt_delay #(.W(TAG_W), .DEPTH(ADC_LAT)) dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tag_live, tag_mon, tag_code}),
        .dout  (tag_late)
    );

    gfmt_pack #(.CODE_W(CODE_W), .MANT_W(MANT_W)) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_live    (tag_late[TAG_W-1]),
        .in_mon     (tag_late[TAG_W-2]),
        .in_code    (tag_late[CODE_W-1:0]),
        .adc_data   (adc_data),
        .word_out   (word_out),
        .word_valid (word_valid)
    );
endmodule

// File: rtl/gain_fmt_chk.sv
// Module: property checker for gain_fmt_top, attached by bind.
module gain_fmt_chk #(
    parameter int N_PATH = 4,
    parameter int CODE_W = 2,
    parameter int MANT_W = 12,
    parameter int WORD_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PATH-1:0] sat_flags,
    input logic              mon_mode,
    input logic [CODE_W-1:0] mon_chan,
    input logic [MANT_W-1:0] adc_data,
    input logic [CODE_W:0]   mux_sel,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid
);
    AST_TOP_GAIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_mode && !sat_flags[0]) |=> (mux_sel == '0));                     // R1
    AST_ALL_SAT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_mode && (&sat_flags)) |=> (mux_sel == {1'b0, {CODE_W{1'b1}}}));  // R2
    AST_MON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        mon_mode |=> (mux_sel == {1'b1, $past(mon_chan)}));                    // R4
    AST_MANT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_out[MANT_W-1:0] == $past(adc_data)));             // R6
    AST_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(rst_n));                                          // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (word_out == '0));                                     // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && word_out == '0 && mux_sel == {1'b0, {CODE_W{1'b1}}})); // R9
endmodule

bind gain_fmt_top gain_fmt_chk #(
    .N_PATH(N_PATH), .CODE_W(CODE_W), .MANT_W(MANT_W), .WORD_W(WORD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sat_flags  (sat_flags),
    .mon_mode   (mon_mode),
    .mon_chan   (mon_chan),
    .adc_data   (adc_data),
    .mux_sel    (mux_sel),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/gain_fmt_top_tb_top.sv
module gain_fmt_top_tb_top;
    localparam int LAT  = 3;
    localparam int HMAX = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sat_flags = 4'hF;
    logic        mon_mode = 1'b0;
    logic [1:0]  mon_chan = 2'd0;
    logic [11:0] adc_data = 12'd0;
    logic [2:0]  mux_sel;
    logic [14:0] word_out;
    logic        word_valid;

    int checks = 0;
    int errors = 0;
    int edge_n = -1;
    bit done = 1'b0;

    int h_rst  [HMAX];
    int h_sat  [HMAX];
    int h_mon  [HMAX];
    int h_chan [HMAX];
    int run    [HMAX];

    gain_fmt_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sat_flags  (sat_flags),
        .mon_mode   (mon_mode),
        .mon_chan   (mon_chan),
        .adc_data   (adc_data),
        .mux_sel    (mux_sel),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    always #2 clk = ~clk;

    // Mantissa the converter model returns for the sample selected at edge s.
    function automatic int mant_of(int s);
        return (s * 613 + 91) & 'hFFF;
    endfunction

    // Expected select {mon, code} for the inputs seen at edge e.
    function automatic int sel_of(int e);
        int c;
        if (h_mon[e] != 0) return 4 + h_chan[e];
        c = 3;
        for (int i = 3; i >= 0; i--) if (((h_sat[e] >> i) & 1) == 0) c = i;
        return c;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s edge %0d actual 0x%0h expected 0x%0h", req, edge_n, act, exp);
        end
    endtask

    // Record the inputs seen at each rising edge.
    always @(posedge clk) begin
        edge_n++;
        h_rst[edge_n]  = rst_n ? 0 : 1;
        h_sat[edge_n]  = sat_flags;
        h_mon[edge_n]  = mon_mode;
        h_chan[edge_n] = mon_chan;
        run[edge_n]    = rst_n ? ((edge_n > 0) ? run[edge_n-1] + 1 : 1) : 0;
    end

    // Compare with the reference model and drive the converter model.
    always @(negedge clk) begin
        if (edge_n >= 0 && !done) begin
            int e, exp_sel, exp_valid, exp_word, s;
            string sreq;
            e = edge_n;
            if (h_rst[e] != 0) begin
                check("R9", mux_sel, 3);
                check("R9", word_valid, 0);
                check("R9", word_out, 0);
            end else begin
                exp_sel = sel_of(e);
                // R3: the select follows the inputs of this edge
                if (h_mon[e] != 0) sreq = "R4";
                else if (h_sat[e] == 15) sreq = "R2";
                else sreq = "R1";
                check(sreq, mux_sel, exp_sel);
                exp_valid = (run[e] >= LAT + 2) ? 1 : 0;
                check("R7", word_valid, exp_valid);
                if (exp_valid != 0) begin
                    s = e - LAT - 1;
                    // R5 packing: flag at 14, code 13:12, mantissa 11:0
                    exp_word = (sel_of(s) << 12) | mant_of(s);
                    check((h_mon[s] != 0) ? "R10" : "R6", word_out, exp_word);
                end else begin
                    check("R8", word_out, 0);
                end
            end
            adc_data <= 12'(mant_of(e - LAT));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // Watchdog
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // Fill phase and random data-mode patterns (R1, R7)
        for (int i = 0; i < 120; i++) begin
            sat_flags = 4'($urandom);
            step(1);
        end
        // Directed priority patterns (R1, R2)
        for (int p = 0; p < 16; p++) begin
            sat_flags = 4'(p);
            step(1);
        end
        sat_flags = 4'b1010; step(2);
        sat_flags = 4'b0111; step(2);
        sat_flags = 4'b1111; step(3);
        sat_flags = 4'b0000; step(2);
        // Monitor mode on every channel, flags changing (R4, R10)
        for (int c = 0; c < 4; c++) begin
            mon_mode = 1'b1;
            mon_chan = 2'(c);
            for (int k = 0; k < 3; k++) begin
                sat_flags = 4'($urandom);
                step(1);
            end
        end
        mon_mode = 1'b0;
        step(6);
        // Reset in the middle of the run (R9, R7)
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            mon_mode  = (i % 7 == 3);
            mon_chan  = 2'($urandom);
            sat_flags = 4'($urandom);
            step(1);
        end
        step(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule